// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block gathers level-sensitive interrupt requests from up to 32 device slots, each offering four interrupt pins (INTA to INTD), and merges them onto four shared bus interrupt lines. Before merging, each slot's pins are rotated by the slot number. This spreads devices that only use INTA across all four lines.

The four bus lines are then steered onto sixteen legacy interrupt-controller inputs. One 8-bit routing register per bus line selects the target input. Routing values of 16 and above leave a line unconnected. Several lines may share one controller input, which is then the OR of those lines. Both the bus line levels and the controller request levels are registered outputs. A routing register is written through a simple select/data/enable port.

Top module: `pci_irq_router`

## Requirements
- R1: Pin p of slot s drives bus line (p + s - 1) mod 4. The pin is read from `dev_irq[s*4 + p]`, and pins 0 to 3 stand for INTA to INTD.
- R2: A bus line is high while at least one pin mapped to it is high. When one device releases its pin, the line stays high if another device still holds a pin on that line.
- R3: When `route_wr_en` is high at a rising edge, `route_wr_data` is stored in the routing register of bus line `route_wr_sel`. `ctrl_irq` reflects the new routing from the next rising edge onward, recomputed from the present line levels.
- R4: Bit 7 of a routing register is ignored. Bits 6:0 select the controller input, so 0x8A routes the same way as 0x0A.
- R5: A line whose routing value (bits 6:0) is 16 or more drives no controller input.
- R6: A controller input selected by several bus lines is high while any of those lines is high.
- R7: `bus_line` and `ctrl_irq` are registered and change one clock edge after the `dev_irq` change that causes them, never earlier.
- R8: A synchronous active-low reset clears both outputs to zero and sets every routing register to 0xFF, which leaves all lines unrouted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq | input | 128 | Pin levels, bit s*4+p is pin p of slot s |
| route_wr_en | input | 1 | Routing register write strobe |
| route_wr_sel | input | 2 | Bus line whose routing register is written |
| route_wr_data | input | 8 | Routing value to store |
| bus_line | output | 4 | Registered shared bus interrupt line levels |
| ctrl_irq | output | 16 | Registered interrupt-controller request levels |

## Verification
The hardest case to reach is a routing change made while lines are already asserted. The controller outputs must move over to the new target one edge after the write, with no fresh pin event to prompt the change. The stimulus holds a fixed set of pins high and rewrites a routing register underneath them. It then samples `ctrl_irq` in the half cycle right after the write edge, where the old routing must still show, and again one edge later, where the new routing must show. A second hard case is a shared line. Two devices in different slots whose rotations land on the same line are raised and then released one at a time.

// File: rtl/pci_irq_pkg.sv
// Shared constants for the interrupt swizzle/router.
// Assumes a fixed four-pin, four-line bus; only slot and controller counts vary.
package pci_irq_pkg;
    localparam int LINES      = 4;
    localparam int PINS       = 4;
    localparam int LINE_SEL_W = $clog2(LINES);
endpackage

// File: rtl/irq_swizzle.sv
// Rotates each slot's four pins by (slot - 1) and wire-ORs them per bus line.
// Purely combinational; assumes dev_irq bit s*4+p is pin p of slot s.
module irq_swizzle #(
    parameter int SLOTS = 32
) (
    input  logic [SLOTS*pci_irq_pkg::PINS-1:0] dev_irq,
    output logic [pci_irq_pkg::LINES-1:0]      line
);
    import pci_irq_pkg::*;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [SLOTS-1:0] contrib;
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            // pin that lands on line l for slot s
            localparam int PIN = (((l - s + 1) % PINS) + PINS) % PINS;
            assign contrib[s] = dev_irq[s*PINS + PIN];
        end
        // any asserted contributor holds the line
        assign line[l] = |contrib;
    end

    // R2: with every pin low no line may be high
    always_comb begin
        if (dev_irq == '0) begin
            a_quiet_lines_r2: assert (line == '0);
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
// Holds one routing byte per bus line, written through a select/data strobe.
// Assumes synchronous active-low reset; reset value leaves lines unrouted.
module irq_route_regs #(
    parameter int ROUTE_W   = 8,
    parameter logic [ROUTE_W-1:0] RESET_VAL = '1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [pci_irq_pkg::LINE_SEL_W-1:0] wr_sel,
    input  logic [ROUTE_W-1:0]                wr_data,
    output logic [ROUTE_W-1:0]                route [pci_irq_pkg::LINES]
);
    import pci_irq_pkg::*;

    for (genvar l = 0; l < LINES; l++) begin : g_reg
        // store a new routing byte when this line is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route[l] <= RESET_VAL;
            end else if (wr_en && (wr_sel == LINE_SEL_W'(l))) begin
                route[l] <= wr_data;
            end
        end
    end

    // R3: a write lands in the addressed register
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> route[$past(wr_sel)] == $past(wr_data));

    // R3: without a write the registers hold
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> (route[0] == $past(route[0]) && route[1] == $past(route[1])
                         && route[2] == $past(route[2]) && route[3] == $past(route[3])));
endmodule

// File: rtl/irq_fanout.sv
// Steers each bus line onto the controller input named by bits below the MSB of
// its routing byte; values beyond the input count match nothing.
// Purely combinational; the routing MSB is masked off.
module irq_fanout #(
    parameter int ROUTE_W     = 8,
    parameter int CTRL_INPUTS = 16
) (
    input  logic [pci_irq_pkg::LINES-1:0] line,
    input  logic [ROUTE_W-1:0]            route [pci_irq_pkg::LINES],
    output logic [CTRL_INPUTS-1:0]        ctrl
);
    import pci_irq_pkg::*;

    localparam logic [ROUTE_W-1:0] SEL_MASK = {1'b0, {(ROUTE_W-1){1'b1}}};

    logic [ROUTE_W-1:0] sel [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_sel
        assign sel[l] = route[l] & SEL_MASK;
    end

    for (genvar c = 0; c < CTRL_INPUTS; c++) begin : g_ctrl
        logic [LINES-1:0] hit;
        for (genvar l = 0; l < LINES; l++) begin : g_hit
            // line l reaches input c only when its selector names c
            assign hit[l] = line[l] && (sel[l] == ROUTE_W'(c));
        end
        assign ctrl[c] = |hit;
    end
endmodule

// File: rtl/pci_irq_router.sv
// Top of the interrupt swizzle/router: combines slot pins onto four bus lines,
// fans them onto controller inputs, and registers both results.
// Assumes level-sensitive inputs already synchronous to clk.
module pci_irq_router #(
    parameter int SLOTS       = 32,
    parameter int CTRL_INPUTS = 16,
    parameter int ROUTE_W     = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [SLOTS*pci_irq_pkg::PINS-1:0]   dev_irq,
    input  logic                                route_wr_en,
    input  logic [pci_irq_pkg::LINE_SEL_W-1:0]   route_wr_sel,
    input  logic [ROUTE_W-1:0]                  route_wr_data,
    output logic [pci_irq_pkg::LINES-1:0]        bus_line,
    output logic [CTRL_INPUTS-1:0]              ctrl_irq
);
    import pci_irq_pkg::*;

    logic [LINES-1:0]       line_now;
    logic [ROUTE_W-1:0]     route [LINES];
    logic [CTRL_INPUTS-1:0] ctrl_now;

    irq_swizzle #(.SLOTS(SLOTS)) u_swizzle (
        .dev_irq (dev_irq),
        .line    (line_now)
    );

    irq_route_regs #(.ROUTE_W(ROUTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (route_wr_en),
        .wr_sel  (route_wr_sel),
        .wr_data (route_wr_data),
        .route   (route)
    );

    irq_fanout #(.ROUTE_W(ROUTE_W), .CTRL_INPUTS(CTRL_INPUTS)) u_fanout (
        .line  (line_now),
        .route (route),
        .ctrl  (ctrl_now)
    );

    // register line and controller levels together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_line <= '0;
            ctrl_irq <= '0;
        end else begin
            bus_line <= line_now;
            ctrl_irq <= ctrl_now;
        end
    end

    // R6: a controller request needs at least one active bus line
    p_ctrl_needs_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctrl_irq) |-> (|bus_line));

    // R5: each line reaches at most one input, so requests never outnumber lines
    p_fanout_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctrl_irq) <= $countones(bus_line));

    // R8: reset leaves both outputs clear
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (bus_line == '0 && ctrl_irq == '0));

    // R7: outputs only move across a clock edge from a registered value
    p_line_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (dev_irq == '0) && $stable(dev_irq) |=> (bus_line == '0));
endmodule

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [127:0]   dev_irq;
    logic           route_wr_en;
    logic [1:0]     route_wr_sel;
    logic [7:0]     route_wr_data;
    logic [3:0]     bus_line;
    logic [15:0]    ctrl_irq;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] routes_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
        .route_wr_en(route_wr_en), .route_wr_sel(route_wr_sel),
        .route_wr_data(route_wr_data), .bus_line(bus_line), .ctrl_irq(ctrl_irq)
    );

    function automatic logic [3:0] exp_lines(input logic [127:0] d);
        logic [3:0] r = '0;
        for (int s = 0; s < SLOTS; s++)
            for (int p = 0; p < 4; p++)
                if (d[s*4+p]) r[(p + s + 3) % 4] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] exp_ctrl(input logic [3:0] ln);
        logic [15:0] r = '0;
        for (int l = 0; l < 4; l++) begin
            int v = int'(routes_m[l] & 8'h7F);
            if (ln[l] && v < 16) r[v] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_dev(input logic [127:0] d);
        @(negedge clk);
        dev_irq = d;
        @(negedge clk);
    endtask

    task automatic write_route(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        route_wr_en = 1'b1; route_wr_sel = sel; route_wr_data = data;
        @(negedge clk);
        route_wr_en = 1'b0;
        routes_m[sel] = data;
    endtask

    task automatic t_reset;
        check("R8 reset bus_line", {12'h0, bus_line}, 16'h0);
        check("R8 reset ctrl_irq", ctrl_irq, 16'h0);
    endtask

    task automatic t_mapping;
        int slots [6] = '{0, 1, 2, 3, 5, 31};
        foreach (slots[i]) begin
            for (int p = 0; p < 4; p++) begin
                logic [127:0] d = '0;
                d[slots[i]*4 + p] = 1'b1;
                apply_dev(d);
                check("R1 swizzle", {12'h0, bus_line}, {12'h0, exp_lines(d)});
            end
        end
        apply_dev('0);
    endtask

    task automatic t_share;
        logic [127:0] d = '0;
        d[1*4+0] = 1'b1;   // slot 1 INTA -> line 0
        d[2*4+3] = 1'b1;   // slot 2 INTD -> line 0
        apply_dev(d);
        check("R2 two holders", {12'h0, bus_line}, 16'h0001);
        d[1*4+0] = 1'b0;
        apply_dev(d);
        check("R2 one released", {12'h0, bus_line}, 16'h0001);
        d[2*4+3] = 1'b0;
        apply_dev(d);
        check("R2 both released", {12'h0, bus_line}, 16'h0000);
    endtask

    task automatic t_latency;
        logic [127:0] d = '0;
        d[4*4+1] = 1'b1;   // slot 4 INTB -> line 0
        @(negedge clk);
        dev_irq = d;
        #1;
        check("R7 before edge", {12'h0, bus_line}, 16'h0000);
        @(negedge clk);
        check("R7 after edge", {12'h0, bus_line}, 16'h0001);
        apply_dev('0);
    endtask

    task automatic t_route;
        logic [127:0] d;
        write_route(2'd0, 8'h05);
        write_route(2'd1, 8'h8A);   // R4: MSB ignored -> 10
        write_route(2'd2, 8'h20);   // R5: unrouted
        write_route(2'd3, 8'h05);   // R6: shares input 5
        for (int l = 0; l < 4; l++) begin
            d = '0;
            d[1*4 + l] = 1'b1;     // slot 1 pin l -> line l
            apply_dev(d);
            check("R4 R5 single line route", ctrl_irq, exp_ctrl(bus_line));
            check("R3 route model", ctrl_irq, exp_ctrl(exp_lines(d)));
        end
        d = '0; d[1*4+2] = 1'b1;
        apply_dev(d);
        check("R5 unrouted line", ctrl_irq, 16'h0000);
        d = '0; d[1*4+0] = 1'b1; d[1*4+3] = 1'b1;
        apply_dev(d);
        check("R6 shared both", ctrl_irq, 16'h0020);
        d[1*4+0] = 1'b0;
        apply_dev(d);
        check("R6 shared one left", ctrl_irq, 16'h0020);
        d = '0; d[1*4+1] = 1'b1;
        apply_dev(d);
        check("R4 msb ignored", ctrl_irq, 16'h0400);
        apply_dev('0);
    endtask

    task automatic t_route_timing;
        logic [127:0] d = '0;
        d[1*4+0] = 1'b1;            // line 0 held, routed to 5
        apply_dev(d);
        check("R3 before rewrite", ctrl_irq, 16'h0020);
        write_route(2'd0, 8'h0C);   // now at negedge after write edge
        check("R3 old route until next edge", ctrl_irq, 16'h0020);
        @(negedge clk);
        check("R3 new route active", ctrl_irq, 16'h1000);
        check("R3 line unchanged", {12'h0, bus_line}, 16'h0001);
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset clears lines", {12'h0, bus_line}, 16'h0);
        check("R8 reset clears ctrl", ctrl_irq, 16'h0);
        rst_n = 1'b1;
        for (int l = 0; l < 4; l++) routes_m[l] = 8'hFF;
        @(negedge clk);
        check("R8 line returns", {12'h0, bus_line}, 16'h0001);
        check("R8 routes unrouted", ctrl_irq, 16'h0000);
    endtask

    initial begin
        rst_n = 1'b0; dev_irq = '0;
        route_wr_en = 1'b0; route_wr_sel = '0; route_wr_data = '0;
        for (int l = 0; l < 4; l++) routes_m[l] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_share();
        t_latency();
        t_route();
        t_route_timing();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule